// File: doc/BRIEF.md
# Pad Output Function Selector

This block sits between a set of on-chip function sources and a row of I/O pads. Every pad owns a two-bit selection register. The register names one of four function slots. The pad's drive level and its drive enable are both taken from that slot through the same select, so a pad can never be driven by two functions at once. The four slots form a fixed map that is shared by every pad.

Each slot is set up at build time in one of three ways:
- **Bus slot.** The function has a bidirectional data line, so it supplies its own enable and decides the pad direction.
- **Output-only slot.** The enable is tied high.
- **Input-only slot.** The enable is tied low.

General-purpose I/O is just another slot, and it is placed in slot 0 as a bus slot. Since registers clear to 0, every pad comes up under general-purpose control and stays an input until that function raises its enable.

The block also hands the sensed pad level back to the separate input router. This level is gated to 0 while the pad is driving. Software changes a selection through a simple write port that carries a pin index and a slot number.

Top module: `pinmux_out_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every pad's selection register becomes 0. After reset, every pad therefore follows slot 0.
- R2: A write with `wr_en` high at a rising edge loads `wr_sel` into the register of pad `wr_pin`. The pad outputs show the new slot right after that edge. No other pad's register changes.
- R3: A write whose `wr_pin` is not below `NPIN` changes no register.
- R4: `pad_out[p]` equals `fn_out[p*4+s]`, where s is the current selection of pad p.
- R5: When slot s is a bus slot (bit s of `SLOT_IS_BUS` is 1), `pad_oe[p]` equals `fn_oe[p*4+s]`.
- R6: When slot s is not a bus slot, `pad_oe[p]` equals bit s of `SLOT_FIXED_OE`, and `fn_oe[p*4+s]` has no effect. With the defaults, slot 1 is output-only (enable 1) and slot 2 is input-only (enable 0).
- R7: `pad_ie[p]` is always the inverse of `pad_oe[p]`.
- R8: `in_level[p]` equals `pad_in[p]` while `pad_ie[p]` is 1, and is 0 otherwise.
- R9: A write presented while `rst` is high has no effect. Reset takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Selection write strobe |
| wr_pin | input | PIN_W | Pad index of the write |
| wr_sel | input | 2 | Slot number to store |
| fn_out | input | NPIN*4 | Function drive values, bit p*4+s for pad p slot s |
| fn_oe | input | NPIN*4 | Function drive enables, same layout |
| pad_in | input | NPIN | Sensed pad levels |
| pad_out | output | NPIN | Drive level to each pad |
| pad_oe | output | NPIN | Drive enable to each pad |
| pad_ie | output | NPIN | Input enable to each pad |
| in_level | output | NPIN | Gated pad level for the input router |

## Verification
The only state in the block is the selection register. A write therefore appears on the pad outputs one rising edge after it is presented, and all other results follow their inputs within the same cycle. The bench drives new inputs on the falling edge and compares every output shortly afterwards, against a model whose selections advance only at the rising edge. Any delay in taking a write, an early write, or a stray change shows up as a mismatch.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int SLOTS = 4;
    localparam int SEL_W = 2;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [1:0] {
        DIR_BUS   = 2'd0,
        DIR_OUT   = 2'd1,
        DIR_IN    = 2'd2
    } dir_kind_t;

    typedef struct packed {
        logic val;
        logic oe;
    } drive_t;

    // Classify a slot from its build-time flags.
    function automatic dir_kind_t slot_kind(input logic is_bus, input logic fixed_oe);
        if (is_bus)
            return DIR_BUS;
        else if (fixed_oe)
            return DIR_OUT;
        else
            return DIR_IN;
    endfunction

    // Resolve the pad drive from a slot's kind and the function's wires.
    function automatic drive_t resolve(input dir_kind_t kind, input logic val, input logic oe);
        drive_t d;
        d.val = val;
        case (kind)
            DIR_BUS: d.oe = oe;
            DIR_OUT: d.oe = 1'b1;
            default: d.oe = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pinmux_sel_bank.sv
module pinmux_sel_bank
    import pinmux_pkg::*;
#(
    parameter int NPIN  = 3,
    parameter int PIN_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [PIN_W-1:0]      wr_pin,
    input  sel_t                  wr_sel,
    output logic [NPIN*SEL_W-1:0] sel_flat
);

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_reg
            sel_t sel_q;
            logic hit;

            assign hit = wr_en && (int'(wr_pin) == p);

            always_ff @(posedge clk) begin
                if (rst)
                    sel_q <= '0;
                else if (hit)
                    sel_q <= wr_sel;
            end

            assign sel_flat[p*SEL_W +: SEL_W] = sel_q;
        end
    endgenerate

endmodule

// File: rtl/pinmux_pin_mux.sv
module pinmux_pin_mux
    import pinmux_pkg::*;
#(
    parameter logic [SLOTS-1:0] SLOT_IS_BUS   = 4'b1001,
    parameter logic [SLOTS-1:0] SLOT_FIXED_OE = 4'b0010
) (
    input  sel_t             sel,
    input  logic [SLOTS-1:0] fn_out,
    input  logic [SLOTS-1:0] fn_oe,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             pad_ie,
    output logic             in_level
);

    drive_t slot_drv [SLOTS];
    drive_t chosen;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            localparam dir_kind_t KIND = slot_kind(SLOT_IS_BUS[s], SLOT_FIXED_OE[s]);
            assign slot_drv[s] = resolve(KIND, fn_out[s], fn_oe[s]);
        end
    endgenerate

    // One select steers value and enable together.
    assign chosen   = slot_drv[sel];
    assign pad_out  = chosen.val;
    assign pad_oe   = chosen.oe;
    assign pad_ie   = ~chosen.oe;
    assign in_level = pad_in & ~chosen.oe;

endmodule

// File: rtl/pinmux_out_top.sv
module pinmux_out_top
    import pinmux_pkg::*;
#(
    parameter int                NPIN          = 3,
    parameter int                PIN_W         = (NPIN > 1) ? $clog2(NPIN) + ((NPIN & (NPIN - 1)) == 0 ? 0 : 0) : 1,
    parameter logic [SLOTS-1:0]  SLOT_IS_BUS   = 4'b1001,
    parameter logic [SLOTS-1:0]  SLOT_FIXED_OE = 4'b0010
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [PIN_W-1:0]      wr_pin,
    input  logic [1:0]            wr_sel,
    input  logic [NPIN*SLOTS-1:0] fn_out,
    input  logic [NPIN*SLOTS-1:0] fn_oe,
    input  logic [NPIN-1:0]       pad_in,
    output logic [NPIN-1:0]       pad_out,
    output logic [NPIN-1:0]       pad_oe,
    output logic [NPIN-1:0]       pad_ie,
    output logic [NPIN-1:0]       in_level
);

    logic [NPIN*SEL_W-1:0] sel_flat;

    pinmux_sel_bank #(
        .NPIN  (NPIN),
        .PIN_W (PIN_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_pin   (wr_pin),
        .wr_sel   (wr_sel),
        .sel_flat (sel_flat)
    );

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            pinmux_pin_mux #(
                .SLOT_IS_BUS   (SLOT_IS_BUS),
                .SLOT_FIXED_OE (SLOT_FIXED_OE)
            ) u_mux (
                .sel      (sel_flat[p*SEL_W +: SEL_W]),
                .fn_out   (fn_out[p*SLOTS +: SLOTS]),
                .fn_oe    (fn_oe[p*SLOTS +: SLOTS]),
                .pad_in   (pad_in[p]),
                .pad_out  (pad_out[p]),
                .pad_oe   (pad_oe[p]),
                .pad_ie   (pad_ie[p]),
                .in_level (in_level[p])
            );
        end
    endgenerate

endmodule

// File: rtl/pinmux_out_chk.sv
module pinmux_out_chk
    import pinmux_pkg::*;
#(
    parameter int               NPIN          = 3,
    parameter int               PIN_W         = 2,
    parameter logic [SLOTS-1:0] SLOT_IS_BUS   = 4'b1001,
    parameter logic [SLOTS-1:0] SLOT_FIXED_OE = 4'b0010
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [PIN_W-1:0]      wr_pin,
    input logic [1:0]            wr_sel,
    input logic [NPIN*SLOTS-1:0] fn_out,
    input logic [NPIN*SLOTS-1:0] fn_oe,
    input logic [NPIN-1:0]       pad_ie,
    input logic [NPIN-1:0]       pad_oe,
    input logic [NPIN-1:0]       pad_out,
    input logic [NPIN-1:0]       in_level,
    input logic [NPIN*SEL_W-1:0] sel_flat
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> sel_flat == '0);

    assert_bad_pin_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_pin) >= NPIN) |=> $stable(sel_flat));

    assert_level_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (pad_ie != '1) |-> ((in_level & ~pad_ie) == '0));

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_p
            assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
                (wr_en && int'(wr_pin) == p) |=> sel_flat[p*SEL_W +: SEL_W] == $past(wr_sel));

            assert_value_routed_R4: assert property (@(posedge clk) disable iff (rst)
                pad_out[p] == fn_out[p*SLOTS + int'(sel_flat[p*SEL_W +: SEL_W])]);

            for (genvar s = 0; s < SLOTS; s++) begin : g_s
                if (SLOT_IS_BUS[s]) begin : g_bus
                    assert_bus_dir_R5: assert property (@(posedge clk) disable iff (rst)
                        (sel_flat[p*SEL_W +: SEL_W] == s) |-> pad_oe[p] == fn_oe[p*SLOTS + s]);
                end else begin : g_fix
                    assert_fixed_dir_R6: assert property (@(posedge clk) disable iff (rst)
                        (sel_flat[p*SEL_W +: SEL_W] == s) |-> pad_oe[p] == SLOT_FIXED_OE[s]);
                end
            end
        end
    endgenerate

endmodule

bind pinmux_out_top pinmux_out_chk #(
    .NPIN          (NPIN),
    .PIN_W         (PIN_W),
    .SLOT_IS_BUS   (SLOT_IS_BUS),
    .SLOT_FIXED_OE (SLOT_FIXED_OE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_pin   (wr_pin),
    .wr_sel   (wr_sel),
    .fn_out   (fn_out),
    .fn_oe    (fn_oe),
    .pad_ie   (pad_ie),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .in_level (in_level),
    .sel_flat (sel_flat)
);

// File: tb/tb_pinmux_out_top.sv
module tb_pinmux_out_top;

    localparam int         NPIN  = 3;
    localparam int         PIN_W = 2;
    localparam int         NS    = 4;
    localparam logic [3:0] BUS   = 4'b1001;
    localparam logic [3:0] FIX   = 4'b0010;

    logic                clk = 1'b0;
    logic                rst;
    logic                wr_en;
    logic [PIN_W-1:0]    wr_pin;
    logic [1:0]          wr_sel;
    logic [NPIN*NS-1:0]  fn_out;
    logic [NPIN*NS-1:0]  fn_oe;
    logic [NPIN-1:0]     pad_in;
    logic [NPIN-1:0]     pad_out;
    logic [NPIN-1:0]     pad_oe;
    logic [NPIN-1:0]     pad_ie;
    logic [NPIN-1:0]     in_level;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int msel [NPIN];

    always #4 clk = ~clk;

    pinmux_out_top dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_pin   (wr_pin),
        .wr_sel   (wr_sel),
        .fn_out   (fn_out),
        .fn_oe    (fn_oe),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .pad_ie   (pad_ie),
        .in_level (in_level)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic cmp(string tag, int p, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pin%0d: actual=%b expected=%b", tag, p, act, exp);
        end
    endtask

    // Compare every pad against the behavioural model.
    task automatic check_all(string ctx);
        for (int p = 0; p < NPIN; p++) begin
            int  s;
            logic eoe;
            s   = msel[p];
            eoe = BUS[s] ? fn_oe[p*NS + s] : FIX[s];
            cmp({ctx, "/R4 value"}, p, pad_out[p], fn_out[p*NS + s]);
            if (BUS[s]) cmp({ctx, "/R5 bus enable"}, p, pad_oe[p], eoe);
            else        cmp({ctx, "/R6 fixed enable"}, p, pad_oe[p], eoe);
            cmp({ctx, "/R7 input enable"}, p, pad_ie[p], ~eoe);
            cmp({ctx, "/R8 level"}, p, in_level[p], pad_in[p] & ~eoe);
        end
    endtask

    // One rising edge: model follows the inputs the bench drove.
    task automatic step();
        @(posedge clk);
        if (rst) begin
            for (int p = 0; p < NPIN; p++) msel[p] = 0;
        end else if (wr_en && int'(wr_pin) < NPIN) begin
            msel[int'(wr_pin)] = int'(wr_sel);
        end
        @(negedge clk);
    endtask

    initial begin
        for (int p = 0; p < NPIN; p++) msel[p] = 0;
        rst    = 1'b1;
        wr_en  = 1'b1;           // R9: write held during reset
        wr_pin = 2'd1;
        wr_sel = 2'd3;
        fn_out = '0;
        fn_oe  = '1;
        pad_in = '1;
        repeat (3) step();

        // R1: after reset all pads on slot 0 (bus, general I/O)
        rst    = 1'b0;
        wr_en  = 1'b0;
        fn_oe  = '0;
        fn_out = 12'hFFF;
        #1;
        for (int p = 0; p < NPIN; p++) begin
            cmp("R1 reset output", p, pad_out[p], 1'b1);
            cmp("R1 reset input mode", p, pad_ie[p], 1'b1);
        end
        check_all("R1");
        // R9: pin 1 still on slot 0 although a write was held in reset
        fn_out = 12'h000;
        fn_out[1*NS + 0] = 1'b1;
        #1;
        cmp("R9 write in reset ignored", 1, pad_out[1], 1'b1);

        // R2: pin 0 to output-only slot 1, others untouched
        wr_en = 1'b1; wr_pin = 2'd0; wr_sel = 2'd1;
        #1;
        cmp("R2 not before edge", 0, pad_oe[0], 1'b0);
        step();
        wr_en = 1'b0;
        fn_oe = '0;
        #1;
        cmp("R2 write landed", 0, pad_oe[0], 1'b1);
        cmp("R2 neighbour kept", 1, pad_oe[1], 1'b0);
        check_all("R2");

        // R6: input-only slot 2 ignores fn_oe
        wr_en = 1'b1; wr_pin = 2'd2; wr_sel = 2'd2;
        step();
        wr_en = 1'b0;
        fn_oe = '1;
        pad_in = 3'b100;
        #1;
        cmp("R6 input-only ignores enable", 2, pad_oe[2], 1'b0);
        cmp("R8 level passed", 2, in_level[2], 1'b1);
        check_all("R6");

        // R3: out-of-range pin index
        wr_en = 1'b1; wr_pin = 2'd3; wr_sel = 2'd3;
        step();
        wr_en = 1'b0;
        #1;
        cmp("R3 pin0 kept", 0, pad_oe[0], 1'b1);
        cmp("R3 pin2 kept", 2, pad_oe[2], 1'b0);
        check_all("R3");

        // Random traffic
        for (int i = 0; i < 2000; i++) begin
            wr_en  = (($urandom % 4) == 0);
            wr_pin = 2'($urandom);
            wr_sel = 2'($urandom);
            fn_out = 12'($urandom);
            fn_oe  = 12'($urandom);
            pad_in = 3'($urandom);
            #1;
            check_all("RND");
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule